// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns a channel-local memory address into a DIMM number, a rank within that DIMM, and an address local to that rank. It holds a small set of rank-range rules and a table of per-way interleave entries. Both are loaded through a simple register write port. A request is a channel address plus a page-policy flag, launched by a one-cycle `start`.

The block walks the rules in order, one per clock, and stops at the first valid rule whose range holds the address. It then removes the rank interleave at a granularity set by the page policy. From the way index and the matched rule it picks one interleave entry. It subtracts that entry's offset and splits the entry's channel rank into DIMM and rank. A one-cycle `done` pulse marks the result. When no rule matches, `miss` is raised instead and the previous result stays on the outputs.

Top module: `rank_ilv_decoder`

## Requirements
- R1: After reset `done`, `miss`, `rankAddr` and `chanRank` are all zero.
- R2: The interleave shift is 6 when `closedPage` is 1 and 13 when it is 0.
- R3: A rule word has its valid flag in bit 31. Its limit is bits 11..1 placed at address bit 29 and up, with address bits 28..0 all ones. Its way count is 2 raised to bits 29..28.
- R4: Rules are tried in ascending index. A valid rule matches when floor <= address <= limit. The floor starts at 0 and becomes each tried rule's raw limit, with no increment. Invalid rules also raise the floor.
- R5: The rank address is ((address >> shift) / ways) << shift, with the low `shift` bits of the address kept unchanged.
- R6: The way index is (address >> shift) mod ways. The selected entry sits at table index way*4 + rule. That index is written at write address 4 + way*4 + rule, for up to 8 ways.
- R7: The selected entry's bits 15..2, placed at address bit 26 and up, are subtracted from the rank address.
- R8: `chanRank` is entry bits 19..16. `dimmSel` is `chanRank` / 4 and `rankSel` is `chanRank` mod 4.
- R9: When no valid rule matches, `miss` is 1 with `done`, and `rankAddr`, `chanRank`, `dimmSel` and `rankSel` keep their previous values.
- R10: `done` is a single-cycle pulse. A `start` that arrives while a request is in progress is ignored.
- R11: Write addresses 0..3 load rule words 0..3, and 4..35 load interleave entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 6 | Configuration word address |
| cfgWrData | input | 32 | Configuration write data |
| start | input | 1 | Launch a decode (single cycle) |
| chanAddr | input | 40 | Channel-local address, sampled with start |
| closedPage | input | 1 | 1 = closed-page policy, 0 = open-page, sampled with start |
| done | output | 1 | Result valid pulse |
| miss | output | 1 | No rule matched the last request |
| rankAddr | output | 40 | Rank-local address |
| chanRank | output | 4 | Channel rank number |
| dimmSel | output | 2 | DIMM number |
| rankSel | output | 2 | Rank within the DIMM |

## Verification
The rule scan and the request handshake can meet in one cycle. A second `start` is pulsed the cycle after a request launches, while the scan is still stepping through rules, with a different address and page policy. The bench judges the collision by requiring that the result carries the values of the first request only, and that `done` returns low on the following cycle. The miss path and the result commit share the final state. The bench places a miss straight after a hit and checks that the hit's outputs are held unchanged.

// File: rtl/rid_pkg.sv
package rid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } ridState_t;

  typedef struct packed {
    logic loadReq;
    logic stepRule;
    logic commit;
  } ridStrobes_t;
endpackage

// File: rtl/rid_ctrl.sv
module rid_ctrl
  import rid_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ruleHit,
  input  logic        lastRule,
  output ridStrobes_t strobes,
  output logic        done
);
  ridState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) begin
        strobes.loadReq = 1'b1;
        stateNext       = ST_SCAN;
      end
      ST_SCAN: begin
        strobes.stepRule = 1'b1;
        if (ruleHit || lastRule) stateNext = ST_FIN;
      end
      ST_FIN: begin
        strobes.commit = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.commit;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rid_datapath.sv
module rid_datapath
  import rid_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int RULES     = 4,
  parameter int WAY_SLOTS = 8,
  localparam int RULE_IW  = $clog2(RULES),
  localparam int WAY_IW   = $clog2(WAY_SLOTS),
  localparam int ENTRIES  = RULES * WAY_SLOTS,
  localparam int CFG_AW   = $clog2(RULES + ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgWrAddr,
  input  logic [31:0]       cfgWrData,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              closedPage,
  input  ridStrobes_t       strobes,
  output logic              ruleHit,
  output logic              lastRule,
  output logic              miss,
  output logic [ADDR_W-1:0] rankAddr,
  output logic [3:0]        chanRank
);
  localparam int SHIFT_CLOSED = 6;
  localparam int SHIFT_OPEN   = 13;

  logic [31:0] ruleReg  [RULES];
  logic [31:0] entryReg [ENTRIES];

  logic [ADDR_W-1:0]  addrReg, prevLimit;
  logic               closedReg, hitFlag;
  logic [RULE_IW-1:0] ruleIdx;

  // configuration write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RULES; i++)   ruleReg[i]  <= '0;
      for (int i = 0; i < ENTRIES; i++) entryReg[i] <= '0;
    end else if (cfgWrEn) begin
      if (int'(cfgWrAddr) < RULES)
        ruleReg[RULE_IW'(cfgWrAddr)] <= cfgWrData;
      else if (int'(cfgWrAddr) < RULES + ENTRIES)
        entryReg[int'(cfgWrAddr) - RULES] <= cfgWrData;
    end
  end

  // current rule fields
  logic [31:0]       curRule;
  logic [ADDR_W-1:0] curLimit;
  logic [1:0]        waysLog;
  assign curRule  = ruleReg[ruleIdx];
  assign curLimit = ADDR_W'({curRule[11:1], {29{1'b1}}});
  assign waysLog  = curRule[29:28];
  assign ruleHit  = curRule[31] && (prevLimit <= addrReg) && (addrReg <= curLimit);
  assign lastRule = (int'(ruleIdx) == RULES - 1);

  // interleave removal
  logic [ADDR_W-1:0] shifted, lowBits, baseAddr, offset, rankNext;
  logic [WAY_IW-1:0] wayIdx, wayMask;
  logic [31:0]       curEntry;
  int                shiftAmt;

  always_comb begin
    shiftAmt = closedReg ? SHIFT_CLOSED : SHIFT_OPEN;
    shifted  = addrReg >> shiftAmt;
    lowBits  = addrReg & ((ADDR_W'(1) << shiftAmt) - ADDR_W'(1));
    wayMask  = WAY_IW'((1 << waysLog) - 1);
    wayIdx   = shifted[WAY_IW-1:0] & wayMask;
    baseAddr = ((shifted >> waysLog) << shiftAmt) | lowBits;
    curEntry = entryReg[int'(wayIdx) * RULES + int'(ruleIdx)];
    offset   = ADDR_W'({curEntry[15:2], 26'b0});
    rankNext = baseAddr - offset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg   <= '0;
      prevLimit <= '0;
      closedReg <= 1'b0;
      hitFlag   <= 1'b0;
      ruleIdx   <= '0;
      miss      <= 1'b0;
      rankAddr  <= '0;
      chanRank  <= '0;
    end else begin
      if (strobes.loadReq) begin
        addrReg   <= chanAddr;
        closedReg <= closedPage;
        prevLimit <= '0;
        hitFlag   <= 1'b0;
        ruleIdx   <= '0;
      end
      if (strobes.stepRule) begin
        if (ruleHit) hitFlag <= 1'b1;
        else begin
          prevLimit <= curLimit;
          if (!lastRule) ruleIdx <= ruleIdx + 1'b1;
        end
      end
      if (strobes.commit) begin
        miss <= !hitFlag;
        if (hitFlag) begin
          rankAddr <= rankNext;
          chanRank <= curEntry[19:16];
        end
      end
    end
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.loadReq, strobes.stepRule, strobes.commit}));

  // R9
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobes.commit) && miss) |-> $stable(rankAddr));

  // R5
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobes.commit) && !miss && closedReg) |-> (rankAddr[5:0] == addrReg[5:0]));
endmodule

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder
  import rid_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int RULES     = 4,
  parameter int WAY_SLOTS = 8,
  localparam int CFG_AW   = $clog2(RULES + RULES * WAY_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgWrAddr,
  input  logic [31:0]       cfgWrData,
  input  logic              start,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              closedPage,
  output logic              done,
  output logic              miss,
  output logic [ADDR_W-1:0] rankAddr,
  output logic [3:0]        chanRank,
  output logic [1:0]        dimmSel,
  output logic [1:0]        rankSel
);
  ridStrobes_t strobes;
  logic        ruleHit, lastRule;

  rid_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ruleHit(ruleHit),
    .lastRule(lastRule), .strobes(strobes), .done(done)
  );

  rid_datapath #(.ADDR_W(ADDR_W), .RULES(RULES), .WAY_SLOTS(WAY_SLOTS)) i_dp (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .chanAddr(chanAddr), .closedPage(closedPage),
    .strobes(strobes), .ruleHit(ruleHit), .lastRule(lastRule), .miss(miss),
    .rankAddr(rankAddr), .chanRank(chanRank)
  );

  assign dimmSel = chanRank[3:2];
  assign rankSel = chanRank[1:0];
endmodule

// File: tb/test_rank_ilv_decoder.sv
module test_rank_ilv_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfgWrEn = 1'b0, start = 1'b0, closedPage = 1'b0;
  logic [5:0]  cfgWrAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [39:0] chanAddr = '0;
  logic        done, miss;
  logic [39:0] rankAddr;
  logic [3:0]  chanRank;
  logic [1:0]  dimmSel, rankSel;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_ilv_decoder i_rank_ilv_decoder (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .start(start), .chanAddr(chanAddr),
    .closedPage(closedPage), .done(done), .miss(miss), .rankAddr(rankAddr),
    .chanRank(chanRank), .dimmSel(dimmSel), .rankSel(rankSel)
  );

  typedef struct packed {
    logic [39:0] addr;
    logic        closed;
    logic        expMiss;
    logic [39:0] expRank;
    logic [3:0]  expCr;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{40'h0000012345, 1'b1, 1'b0, 40'h0000012345, 4'd5},
    '{40'h0000012345, 1'b0, 1'b0, 40'h0000012345, 4'd5},
    '{40'h0040000040, 1'b1, 1'b0, 40'h0000000000, 4'd7},
    '{40'h0040000040, 1'b0, 1'b0, 40'h0010000040, 4'd2},
    '{40'h003FFFFFFF, 1'b1, 1'b0, 40'h003FFFFFFF, 4'd5},
    '{40'h0090000000, 1'b1, 1'b1, 40'h003FFFFFFF, 4'd5},
    '{40'h00C00000C0, 1'b1, 1'b0, 40'h0010000000, 4'd11},
    '{40'h00C0002080, 1'b0, 1'b0, 40'h0010000080, 4'd9},
    '{40'h0100000000, 1'b1, 1'b1, 40'h0010000080, 4'd9},
    '{40'h00BFFFFFFF, 1'b1, 1'b0, 40'h000FFFFFFF, 4'd11}
  };

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = 6'(a); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic launch(input logic [39:0] a, input logic c);
    @(negedge clk);
    chanAddr = a; closedPage = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R10 done seen", 40'(done), 40'd1);
  endtask

  task automatic checkResult(input vec_t v);
    check("R9 miss flag", 40'(miss), 40'(v.expMiss));
    check("R5/R7 rankAddr", rankAddr, v.expRank);
    check("R8 chanRank", 40'(chanRank), 40'(v.expCr));
    check("R8 dimmSel", 40'(dimmSel), 40'(v.expCr >> 2));
    check("R8 rankSel", 40'(rankSel), 40'(v.expCr & 4'd3));
    @(negedge clk);
    check("R10 done single pulse", 40'(done), 40'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", 40'(done), 40'd0);
    check("R1 miss", 40'(miss), 40'd0);
    check("R1 rankAddr", rankAddr, 40'd0);
    check("R1 chanRank", 40'(chanRank), 40'd0);
    rst_n = 1'b1;

    // R11 R3 rule words: valid bit31, limit bits 11..1, ways bits 29..28
    cfgWrite(0, 32'h80000002);
    cfgWrite(1, 32'h90000006);
    cfgWrite(2, 32'h0000000A);
    cfgWrite(3, 32'hA000000E);
    // R6 entries at 4 + way*4 + rule
    cfgWrite(4 + 0*4 + 0, 32'h00050000);
    cfgWrite(4 + 0*4 + 1, 32'h00020010);
    cfgWrite(4 + 1*4 + 1, 32'h00070020);
    for (int w = 0; w < 4; w++)
      cfgWrite(4 + w*4 + 3, 32'h00080020 + (32'(w) << 16));

    // R2 R4 R5 R6 R7 R9 vector walk
    for (int i = 0; i < NVEC; i++) begin
      launch(VECS[i].addr, VECS[i].closed);
      waitDone();
      checkResult(VECS[i]);
    end

    // R10 start during busy scan is ignored
    @(negedge clk);
    chanAddr = 40'h00C00000C0; closedPage = 1'b1; start = 1'b1;
    @(negedge clk);
    chanAddr = 40'h0000012345; closedPage = 1'b0;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    checkResult(VECS[6]);
    repeat (4) @(negedge clk);
    check("R10 no second done", 40'(done), 40'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule